// File: doc/BRIEF.md
# Condition-Bit Reduction Sequencer

This block steps through the elements of a vectorised condition-bit logical operation (AND or OR) and applies each element's result to a small condition-bit array that the block holds. For element `e`, each of the two sources and the destination is addressed as field `(base + e) mod NUM_FIELDS`. All three operands use the same bit selector inside that field. The block has no reduction instruction. A reduction comes from the fixed element order, which can be reversed, acting on operands that overlap.

Each element is a read-modify-write that finishes in one clock. The next element therefore reads any bit the previous element wrote. When one source sits one field above the destination and the other source, a value cascades through the vector. With AND, one zero clears every element processed after it.

Before a run, the array is loaded through a load port. After `done`, the result is read from `cr_out`. Mode encodings that this block does not execute raise `unsupported`, and no bit of the array changes.

Top module: `cr_reduce_seq`

## Requirements
- R1: After synchronous active-low reset, `cr_out` is all zero and `busy`, `done` and `unsupported` are low.
- R2: While idle, `cr_load` copies `cr_load_data` into the array, visible on `cr_out` one cycle later. Bit `field*4 + bit_sel` of the array is bit `bit_sel` of field `field`.
- R3: `rm_mode[4:3]` is the two-bit fail-first/predicate selector, `rm_mode[2]` the reduce flag, `rm_mode[1]` the parallel flag and `rm_mode[0]` the reverse flag. Selector 00 with reduce=1 and parallel=0 is scalar reduce. Selector 00 with reduce=0 is normal mode, which always runs forward whatever `rm_mode[0]` says.
- R4: In scalar reduce with reverse=1, elements run from VL-1 down to 0. In every other executed case they run from 0 up to VL-1.
- R5: Element `e` writes `A op B` into the destination bit, where op is AND when `op_is_or`=0 and OR when it is 1. Each element reads the bits already written by earlier elements of the same run.
- R6: The field index `base + e` wraps modulo NUM_FIELDS.
- R7: A non-zero selector, or reduce=1 with parallel=1, is unsupported. Such a start writes nothing, gives `done` one cycle after the start edge with `unsupported` high, and `unsupported` stays high until the next accepted start.
- R8: An executed start with VL>0 keeps `busy` high for exactly VL cycles from the cycle after the start edge, then pulses `done` for one cycle. With VL=0 the run writes nothing and `done` pulses in the cycle after the start edge.
- R9: While `busy`, `start` and `cr_load` are ignored. Operand, mode and VL inputs are captured at the accepted start, so later changes to them have no effect on the run.
- R10: While `busy`, at most one array bit changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| rm_mode | input | 5 | Mode bits: [4:3] selector, [2] reduce, [1] parallel, [0] reverse |
| vl | input | VL_W | Vector length |
| src_a_field | input | FIELD_W | Base field of source A |
| src_b_field | input | FIELD_W | Base field of source B |
| dst_field | input | FIELD_W | Base field of the destination |
| bit_sel | input | 2 | Bit within each field, shared by all operands |
| op_is_or | input | 1 | 0 = AND, 1 = OR |
| cr_load | input | 1 | Load the array from `cr_load_data` (idle only) |
| cr_load_data | input | NUM_FIELDS*4 | Load value |
| busy | output | 1 | An element is being processed this cycle |
| done | output | 1 | One-cycle end-of-run pulse |
| unsupported | output | 1 | The last accepted start had an unexecuted mode |
| cr_out | output | NUM_FIELDS*4 | Array contents |

## Verification
The functions that can collide are the per-element read-modify-write and the external array load, together with a second start arriving during a run. One scenario raises `cr_load` with the inverted pattern, and a new `start` with different operands, in the middle of a running reduction. It then requires the final array to match the undisturbed reference result and `done` to arrive on the original schedule. A load and a start given in the same idle cycle check that the run reads the freshly loaded data.

// File: rtl/cr_red_pkg.sv
// Package: shared types for the condition-bit reduction sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package cr_red_pkg;

    // Sequencer state.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_t;

    // Decoded mode.
    typedef struct packed {
        logic exec;      // mode is executed by this block
        logic reverse;   // run from VL-1 down to 0
        logic unsup;     // mode not handled
    } mode_dec_t;

    // Number of operands addressed per element.
    localparam int NUM_OPS  = 3;
    localparam int OP_SRC_A = 0;
    localparam int OP_SRC_B = 1;
    localparam int OP_DST   = 2;

endpackage

// File: rtl/crr_mode_decode.sv
// Module: crr_mode_decode
// Turns the five mode bits into execute / reverse / unsupported flags.
// Bit map: [4:3] fail-first/predicate selector, [2] reduce, [1] parallel,
// [0] reverse. Only scalar reduce and normal mode are executed.
module crr_mode_decode
    import cr_red_pkg::*;
(
    input  logic [4:0] rm_mode,
    output mode_dec_t  dec
);

    logic sel_zero;
    logic is_reduce;
    logic is_parallel;

    // Purpose: classify the mode bits.
    always_comb begin
        sel_zero    = (rm_mode[4:3] == 2'b00);
        is_reduce   = sel_zero && rm_mode[2] && !rm_mode[1];
        is_parallel = sel_zero && rm_mode[2] && rm_mode[1];
        dec.exec    = sel_zero && !is_parallel;
        dec.reverse = is_reduce && rm_mode[0];
        dec.unsup   = !sel_zero || is_parallel;
    end

endmodule

// File: rtl/crr_elem_seq.sv
// Module: crr_elem_seq
// Element scheduler: one element per busy cycle, forward or reverse.
// Assumes start is only acted upon in idle; captures VL and order at start.
module crr_elem_seq
    import cr_red_pkg::*;
#(
    parameter int VL_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            exec,
    input  logic            reverse,
    input  logic [VL_W-1:0] vl,
    output logic            accept,
    output logic            busy,
    output logic            done,
    output logic [VL_W-1:0] elem
);

    seq_state_t      state;
    logic [VL_W-1:0] cnt;
    logic [VL_W-1:0] vl_q;
    logic            rev_q;
    logic            last;

    // Purpose: a start is taken only in idle.
    assign accept = (state == SEQ_IDLE) && start;

    // Purpose: detect the final element of the run.
    assign last = (cnt == vl_q - VL_W'(1));

    // Purpose: state, counter and captured run parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            vl_q  <= '0;
            rev_q <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        cnt   <= '0;
                        vl_q  <= vl;
                        rev_q <= reverse;
                        if (!exec || (vl == '0)) state <= SEQ_FIN;
                        else                     state <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (last) state <= SEQ_FIN;
                    else      cnt   <= cnt + VL_W'(1);
                end
                SEQ_FIN:  state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    // Purpose: map count to element offset in the chosen order.
    always_comb begin
        if (rev_q) elem = vl_q - VL_W'(1) - cnt;
        else       elem = cnt;
    end

    assign busy = (state == SEQ_RUN);
    assign done = (state == SEQ_FIN);

endmodule

// File: rtl/crr_addr_gen.sv
// Module: crr_addr_gen
// Forms a bit address from a base field, an element offset and the bit
// selector. Assumes NUM_FIELDS is a power of two so the wrap is a truncation.
module crr_addr_gen #(
    parameter int NUM_FIELDS = 8,
    parameter int VL_W       = 4
) (
    input  logic [$clog2(NUM_FIELDS)-1:0]   base,
    input  logic [VL_W-1:0]                 elem,
    input  logic [1:0]                      bit_sel,
    output logic [$clog2(NUM_FIELDS)+1:0]   addr
);

    localparam int FIELD_W = $clog2(NUM_FIELDS);
    localparam int SUM_W   = ((FIELD_W > VL_W) ? FIELD_W : VL_W) + 1;

    logic [SUM_W-1:0]   sum;
    logic [FIELD_W-1:0] field;

    // Purpose: add offset and wrap modulo the field count.
    always_comb begin
        sum   = SUM_W'(base) + SUM_W'(elem);
        field = sum[FIELD_W-1:0];
        addr  = {field, bit_sel};
    end

endmodule

// File: rtl/crr_bit_file.sv
// Module: crr_bit_file
// Condition-bit array: two combinational read ports, one write port,
// and a whole-array load. Assumes load and write are never both requested.
module crr_bit_file #(
    parameter int NUM_BITS = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_en,
    input  logic [NUM_BITS-1:0]         load_data,
    input  logic [$clog2(NUM_BITS)-1:0] rd_addr_a,
    input  logic [$clog2(NUM_BITS)-1:0] rd_addr_b,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_BITS)-1:0] wr_addr,
    input  logic                        wr_data,
    output logic                        rd_a,
    output logic                        rd_b,
    output logic [NUM_BITS-1:0]         bits_out
);

    logic [NUM_BITS-1:0] bits_q;

    // Purpose: storage update from load or element write.
    always_ff @(posedge clk) begin
        if (!rst_n)       bits_q          <= '0;
        else if (load_en) bits_q          <= load_data;
        else if (wr_en)   bits_q[wr_addr] <= wr_data;
    end

    // Purpose: read ports.
    assign rd_a     = bits_q[rd_addr_a];
    assign rd_b     = bits_q[rd_addr_b];
    assign bits_out = bits_q;

endmodule

// File: rtl/cr_reduce_seq.sv
// Module: cr_reduce_seq (top)
// Runs a vectorised condition-bit AND/OR over an internal array, one
// read-modify-write per cycle, so overlapping operands cascade.
// Assumes NUM_FIELDS is a power of two; loads are only honoured when idle.
module cr_reduce_seq
    import cr_red_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    parameter int VL_W       = 4,
    localparam int FIELD_W   = $clog2(NUM_FIELDS),
    localparam int NUM_BITS  = NUM_FIELDS * 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [4:0]          rm_mode,
    input  logic [VL_W-1:0]     vl,
    input  logic [FIELD_W-1:0]  src_a_field,
    input  logic [FIELD_W-1:0]  src_b_field,
    input  logic [FIELD_W-1:0]  dst_field,
    input  logic [1:0]          bit_sel,
    input  logic                op_is_or,
    input  logic                cr_load,
    input  logic [NUM_BITS-1:0] cr_load_data,
    output logic                busy,
    output logic                done,
    output logic                unsupported,
    output logic [NUM_BITS-1:0] cr_out
);

    localparam int ADDR_W = FIELD_W + 2;

    mode_dec_t          dec;
    logic               accept;
    logic [VL_W-1:0]    elem;
    logic [FIELD_W-1:0] base_q [NUM_OPS];
    logic [FIELD_W-1:0] base_in [NUM_OPS];
    logic [ADDR_W-1:0]  addr [NUM_OPS];
    logic [1:0]         bsel_q;
    logic               or_q;
    logic               unsup_q;
    logic               rd_a;
    logic               rd_b;
    logic               wr_bit;

    crr_mode_decode u_dec (
        .rm_mode (rm_mode),
        .dec     (dec)
    );

    crr_elem_seq #(.VL_W(VL_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .exec    (dec.exec),
        .reverse (dec.reverse),
        .vl      (vl),
        .accept  (accept),
        .busy    (busy),
        .done    (done),
        .elem    (elem)
    );

    // Purpose: gather operand base inputs in operand order.
    always_comb begin
        base_in[OP_SRC_A] = src_a_field;
        base_in[OP_SRC_B] = src_b_field;
        base_in[OP_DST]   = dst_field;
    end

    // Purpose: capture operands, op and status at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OPS; i++) base_q[i] <= '0;
            bsel_q  <= 2'd0;
            or_q    <= 1'b0;
            unsup_q <= 1'b0;
        end else if (accept) begin
            for (int i = 0; i < NUM_OPS; i++) base_q[i] <= base_in[i];
            bsel_q  <= bit_sel;
            or_q    <= op_is_or;
            unsup_q <= dec.unsup;
        end
    end

    // One address generator per operand.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_addr
        crr_addr_gen #(.NUM_FIELDS(NUM_FIELDS), .VL_W(VL_W)) u_ag (
            .base    (base_q[g]),
            .elem    (elem),
            .bit_sel (bsel_q),
            .addr    (addr[g])
        );
    end

    // Purpose: element result.
    assign wr_bit = or_q ? (rd_a | rd_b) : (rd_a & rd_b);

    crr_bit_file #(.NUM_BITS(NUM_BITS)) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (cr_load && !busy),
        .load_data (cr_load_data),
        .rd_addr_a (addr[OP_SRC_A]),
        .rd_addr_b (addr[OP_SRC_B]),
        .wr_en     (busy),
        .wr_addr   (addr[OP_DST]),
        .wr_data   (wr_bit),
        .rd_a      (rd_a),
        .rd_b      (rd_b),
        .bits_out  (cr_out)
    );

    assign unsupported = unsup_q;

endmodule

// File: rtl/cr_reduce_seq_checker.sv
// Module: cr_reduce_seq_checker
// Temporal checks on the top-level ports, bound into cr_reduce_seq.
module cr_reduce_seq_checker #(
    parameter int NUM_BITS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                cr_load,
    input logic                busy,
    input logic                done,
    input logic                unsupported,
    input logic [NUM_BITS-1:0] cr_out
);

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R8

    AST_ONE_BIT_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(cr_out ^ $past(cr_out)) <= 1)); // R10

    AST_IDLE_HOLDS_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cr_load) |=> $stable(cr_out)); // R7

    AST_UNSUP_NEVER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> !busy); // R7

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done)); // R9

endmodule

bind cr_reduce_seq cr_reduce_seq_checker #(.NUM_BITS(NUM_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cr_load     (cr_load),
    .busy        (busy),
    .done        (done),
    .unsupported (unsupported),
    .cr_out      (cr_out)
);

// File: tb/cr_reduce_seq_test.sv
// Bench: directed scenarios, each task checks its own results.
module cr_reduce_seq_test;

    localparam int NF  = 8;
    localparam int VLW = 4;
    localparam int FW  = $clog2(NF);
    localparam int NB  = NF * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    rm_mode = '0;
    logic [VLW-1:0] vl = '0;
    logic [FW-1:0] src_a_field = '0;
    logic [FW-1:0] src_b_field = '0;
    logic [FW-1:0] dst_field = '0;
    logic [1:0]    bit_sel = '0;
    logic          op_is_or = 1'b0;
    logic          cr_load = 1'b0;
    logic [NB-1:0] cr_load_data = '0;
    logic          busy;
    logic          done;
    logic          unsupported;
    logic [NB-1:0] cr_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cr_reduce_seq #(.NUM_FIELDS(NF), .VL_W(VLW)) uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: in-place element loop from the requirements.
    function automatic logic [NB-1:0] ref_run(input logic [NB-1:0] init, input int n,
        input bit rev, input int a, input int b, input int t, input int bs, input bit is_or);
        logic [NB-1:0] r = init;
        for (int k = 0; k < n; k++) begin
            int e  = rev ? (n - 1 - k) : k;
            logic va = r[((a + e) % NF) * 4 + bs];
            logic vb = r[((b + e) % NF) * 4 + bs];
            r[((t + e) % NF) * 4 + bs] = is_or ? (va | vb) : (va & vb);
        end
        return r;
    endfunction

    task automatic load_array(input logic [NB-1:0] d);
        @(negedge clk);
        cr_load = 1'b1; cr_load_data = d;
        @(negedge clk);
        cr_load = 1'b0;
    endtask

    // Run one case; poke=1 disturbs the run with a load and a start.
    task automatic run_case(input string tag, input logic [NB-1:0] init, input logic [4:0] m,
        input int n, input int a, input int b, input int t, input int bs, input bit is_or,
        input bit poke, output logic [NB-1:0] res);
        bit unsup = (m[4:3] != 2'b00) || (m[2] && m[1]);
        bit rev   = (m[4:3] == 2'b00) && m[2] && !m[1] && m[0];
        logic [NB-1:0] exp = (unsup || n == 0) ? init : ref_run(init, n, rev, a, b, t, bs, is_or);
        int lat = 0;
        int exp_lat = (unsup || n == 0) ? 1 : n + 1;
        load_array(init);
        chk({tag, " R2 load"}, 64'(cr_out), 64'(init));
        rm_mode = m; vl = VLW'(n); src_a_field = FW'(a); src_b_field = FW'(b);
        dst_field = FW'(t); bit_sel = 2'(bs); op_is_or = is_or; start = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
            if (lat == 1) chk({tag, " R8 busy"}, 64'(busy), 64'(!(unsup || n == 0)));
            if (poke && lat == 2) begin
                cr_load = 1'b1; cr_load_data = ~init; start = 1'b1;
                rm_mode = 5'b00100; vl = VLW'(1); src_a_field = FW'(a + 3);
                dst_field = FW'(t + 1); op_is_or = !is_or; bit_sel = 2'(bs + 1);
            end else begin
                cr_load = 1'b0;
            end
            if (done) break;
        end
        cr_load = 1'b0; start = 1'b0;
        chk({tag, " R8 done latency"}, 64'(lat), 64'(exp_lat));
        chk({tag, " R5 array"}, 64'(cr_out), 64'(exp));
        chk({tag, " R7 unsupported"}, 64'(unsupported), 64'(unsup));
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, 64'(done), 64'(0));
        res = cr_out;
    endtask

    task automatic t_reset();
        chk("R1 cr_out", 64'(cr_out), 64'(0));
        chk("R1 busy", 64'(busy), 64'(0));
        chk("R1 done", 64'(done), 64'(0));
        chk("R1 unsupported", 64'(unsupported), 64'(0));
    endtask

    // Reverse AND cascade: one zero in field 5 bit 2 clears fields 0..5.
    task automatic t_reverse_cascade();
        logic [NB-1:0] init = '1;
        logic [NB-1:0] r;
        init[5*4+2] = 1'b0;
        run_case("rev_and", init, 5'b00101, 7, 0, 1, 0, 2, 1'b0, 1'b0, r);
        chk("R5 cascade reaches field0", 64'(r[0*4+2]), 64'(0));
        chk("R4 field6 untouched", 64'(r[6*4+2]), 64'(1));
    endtask

    // Same operands forward: no cascade, only field 4 sees the zero.
    task automatic t_forward_nocascade();
        logic [NB-1:0] init = '1;
        logic [NB-1:0] r;
        init[5*4+2] = 1'b0;
        run_case("fwd_and", init, 5'b00100, 7, 0, 1, 0, 2, 1'b0, 1'b0, r);
        chk("R4 field0 keeps one", 64'(r[0*4+2]), 64'(1));
        chk("R4 field4 cleared", 64'(r[4*4+2]), 64'(0));
    endtask

    // Forward OR cascade upward from field 0.
    task automatic t_or_cascade();
        logic [NB-1:0] r;
        run_case("fwd_or", 32'h0000_0001, 5'b00100, 6, 1, 0, 1, 0, 1'b1, 1'b0, r);
        chk("R5 or reaches field6", 64'(r[6*4]), 64'(1));
    endtask

    task automatic t_wrap();
        logic [NB-1:0] r;
        run_case("wrap", 32'h8A53_C1E7, 5'b00101, 5, 6, 7, 6, 3, 1'b0, 1'b0, r);
        run_case("wrap_or", 32'h1020_0400, 5'b00100, 9, 5, 4, 5, 1, 1'b1, 1'b0, r);
        chk("R6 wrapped to field1", 64'(r[1*4+1]), 64'(1));
    endtask

    // Normal mode ignores the reverse bit.
    task automatic t_normal_mode();
        logic [NB-1:0] init = '1;
        logic [NB-1:0] r;
        init[5*4+2] = 1'b0;
        run_case("normal", init, 5'b00001, 7, 0, 1, 0, 2, 1'b0, 1'b0, r);
        chk("R3 normal runs forward", 64'(r[0*4+2]), 64'(1));
    endtask

    task automatic t_edge_modes();
        logic [NB-1:0] r;
        run_case("vl0", 32'h0F0F_3355, 5'b00100, 0, 0, 1, 0, 0, 1'b0, 1'b0, r);
        run_case("parallel", 32'h0000_00F0, 5'b00110, 4, 0, 1, 0, 0, 1'b0, 1'b0, r);
        run_case("failfirst", 32'h0000_00F0, 5'b01100, 4, 0, 1, 0, 0, 1'b0, 1'b0, r);
        run_case("predres", 32'h0000_00F0, 5'b11101, 4, 0, 1, 0, 0, 1'b0, 1'b0, r);
        run_case("after_unsup", 32'h0000_00F0, 5'b00100, 2, 0, 1, 0, 0, 1'b1, 1'b0, r);
    endtask

    // Load and start during a run must not disturb it.
    task automatic t_collision();
        logic [NB-1:0] init = '1;
        logic [NB-1:0] r;
        init[6*4+3] = 1'b0;
        run_case("R9 busy_poke", init, 5'b00101, 7, 1, 2, 1, 3, 1'b0, 1'b1, r);
        chk("R9 cascade intact", 64'(r[1*4+3]), 64'(0));
    endtask

    // Load and start in the same idle cycle: run reads loaded data.
    task automatic t_load_with_start();
        @(negedge clk);
        cr_load = 1'b1; cr_load_data = 32'h0000_0001;
        rm_mode = 5'b00100; vl = VLW'(3); src_a_field = FW'(1); src_b_field = FW'(0);
        dst_field = FW'(1); bit_sel = 2'd0; op_is_or = 1'b1; start = 1'b1;
        @(negedge clk);
        cr_load = 1'b0; start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 load+start same cycle", 64'(cr_out), 64'(32'h0000_1111));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reverse_cascade();
        t_forward_nocascade();
        t_or_cascade();
        t_wrap();
        t_normal_mode();
        t_edge_modes();
        t_collision();
        t_load_with_start();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule